// File: doc/BRIEF.md
# Masked-Write Clock Gate Bank

This block holds the enable state for a bank of module clock gates and drives one enable line per gate. Software reaches it over a simple memory-mapped register bus. Each 32-bit control word covers sixteen gates. A write to a control word carries its own per-bit write mask in the upper halfword, so any subset of gates in that word can be switched on or off in a single write, without reading the word first.

Each control word has a companion monitor word. A monitor bit reports that its clock is actually running. In this block the monitor is modelled as the enable delayed by a configurable settle time, in both the on and the off direction. Some gates have no monitor. Their monitor bits read as zero. A per-gate status port returns the monitor bit for a gate that has one, and the stored enable bit for a gate that has none. Firmware confirms an enable by polling the monitor word until the bit is set.

Top module: `clk_gate_bank`

## Requirements
- R1: After reset the enable of every gate equals its bit in `CRIT_MASK` (default: gates 0, 15 and 16 on, all others off). The monitor reports the same state at once for every monitored gate.
- R2: A bus write to control word n (byte address 0x600 + 4n, n < `NUM_WORDS`) updates only the data bits [15:0] whose write-mask bit (bit position + 16) is 1. A mask 1 with data 1 turns the gate on, and a mask 1 with data 0 turns it off. Gate number = n·16 + bit position. `gateEn` shows the new value in the cycle after the write edge.
- R3: A read of control word n returns the stored enables of gates n·16..n·16+15 in bits [15:0] and zero in bits [31:16]. `rdData` is valid from the clock edge that samples `rdEn`.
- R4: The monitor bit of a monitored gate takes the value of its enable exactly `SETTLE_CYCLES` clock edges after the enable changes, for both rising and falling changes. It keeps the old value before then.
- R5: A gate whose bit in `MON_MASK` is 0 has no monitor: its bit in the monitor word always reads 0, and `statusOn` for it returns its enable bit in the cycle after the write.
- R6: `statusOn` for gate index g returns that gate's monitor bit when `MON_MASK[g]` is 1.
- R7: Writes to monitor words (0x800 + 4n) and to unmapped or misaligned addresses change no enable.
- R8: A read of an unmapped or misaligned address returns 0. A read of monitor word n at 0x800 + 4n returns the monitor bits of gates n·16..n·16+15 in [15:0] and zero above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Bus write strobe, one cycle per write |
| rdEn | input | 1 | Bus read strobe |
| addr | input | 12 | Byte address |
| wrData | input | 32 | Write data: mask in [31:16], values in [15:0] |
| rdData | output | 32 | Registered read data |
| gateEn | output | NUM_WORDS·16 | Enable line per gate |
| statusIdx | input | clog2(NUM_WORDS·16) | Gate number for the status query |
| statusOn | output | 1 | Status of the gate selected by statusIdx |

## Verification
A write lands on `gateEn` at the clock edge that samples it. The bench therefore checks `gateEn` at the falling edge that follows. A read result is registered on the edge that samples `rdEn`, and the bench samples `rdData` half a cycle later. The monitor trails the enable by exactly `SETTLE_CYCLES` edges. The bench checks `statusOn` of a monitored gate at the falling edge just before that count is reached, where it must still hold the old value, and again at the falling edge just after, where it must hold the new one. Monitor words are read on the bus only after the settle time has passed.

// File: rtl/cgb_pkg.sv
package cgb_pkg;
  localparam int GATES_PER_WORD = 16;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] CTL_BASE = 12'h600;
  localparam logic [ADDR_W-1:0] MON_BASE = 12'h800;
  localparam int IDX_W = 8;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic             ctlWrite;
    logic             ctlRead;
    logic             monRead;
    logic             anyRead;
    logic [IDX_W-1:0] wordIdx;
  } busStrobes_t;
endpackage

// File: rtl/cgb_ctrl.sv
module cgb_ctrl
  import cgb_pkg::*;
#(
  parameter int NUM_WORDS = 2
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output busStrobes_t       strb
);
  logic [ADDR_W-1:0] ctlOff, monOff;
  logic              aligned, ctlHit, monHit;

  always_comb begin
    ctlOff  = addr - CTL_BASE;
    monOff  = addr - MON_BASE;
    aligned = (addr[1:0] == 2'b00);
    ctlHit  = aligned && (addr >= CTL_BASE) && (int'(ctlOff[ADDR_W-1:2]) < NUM_WORDS);
    monHit  = aligned && (addr >= MON_BASE) && (int'(monOff[ADDR_W-1:2]) < NUM_WORDS);

    strb.ctlWrite = wrEn && ctlHit;
    strb.ctlRead  = rdEn && ctlHit;
    strb.monRead  = rdEn && monHit;
    strb.anyRead  = rdEn;
    strb.wordIdx  = ctlHit ? ctlOff[IDX_W+1:2] : monOff[IDX_W+1:2];
  end
endmodule

// File: rtl/cgb_datapath.sv
module cgb_datapath
  import cgb_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int SETTLE_CYCLES = 4,
  parameter logic [NUM_WORDS*GATES_PER_WORD-1:0] CRIT_MASK = '0,
  parameter logic [NUM_WORDS*GATES_PER_WORD-1:0] MON_MASK = '1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  busStrobes_t                       strb,
  input  logic [31:0]                       wrData,
  input  logic [$clog2(NUM_WORDS*GATES_PER_WORD)-1:0] statusIdx,
  output logic [NUM_WORDS*GATES_PER_WORD-1:0] enVec,
  output logic [31:0]                       rdData,
  output logic                              statusOn
);
  localparam int NG = NUM_WORDS * GATES_PER_WORD;

  logic [NG-1:0] monRaw, monVec;
  logic [15:0]   wrMask, wrVal;

  assign wrMask = wrData[31:16];
  assign wrVal  = wrData[15:0];

  // enable storage with per-bit masked update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enVec <= CRIT_MASK;
    end else if (strb.ctlWrite) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (int'(strb.wordIdx) == w) begin
          enVec[w*GATES_PER_WORD +: GATES_PER_WORD] <=
            (enVec[w*GATES_PER_WORD +: GATES_PER_WORD] & ~wrMask) | (wrVal & wrMask);
        end
      end
    end
  end

  // monitor model: enable delayed by SETTLE_CYCLES edges
  generate
    if (SETTLE_CYCLES == 0) begin : g_noDelay
      assign monRaw = enVec;
    end else begin : g_delay
      logic [NG-1:0] monPipe [SETTLE_CYCLES];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int s = 0; s < SETTLE_CYCLES; s++) monPipe[s] <= CRIT_MASK;
        end else begin
          monPipe[0] <= enVec;
          for (int s = 1; s < SETTLE_CYCLES; s++) monPipe[s] <= monPipe[s-1];
        end
      end
      assign monRaw = monPipe[SETTLE_CYCLES-1];
    end
  endgenerate

  assign monVec = monRaw & MON_MASK;

  // registered read mux
  logic [15:0] ctlWordSel, monWordSel;
  always_comb begin
    ctlWordSel = '0;
    monWordSel = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (int'(strb.wordIdx) == w) begin
        ctlWordSel = enVec[w*GATES_PER_WORD +: GATES_PER_WORD];
        monWordSel = monVec[w*GATES_PER_WORD +: GATES_PER_WORD];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.anyRead) begin
      if (strb.ctlRead)      rdData <= {16'h0, ctlWordSel};
      else if (strb.monRead) rdData <= {16'h0, monWordSel};
      else                   rdData <= '0;
    end
  end

  assign statusOn = MON_MASK[statusIdx] ? monVec[statusIdx] : enVec[statusIdx];

  // ---- checks ----
  logic [IDX_W-1:0] lastIdx;
  logic [15:0]      wordAfter;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastIdx <= '0;
    else       lastIdx <= strb.wordIdx;
  end
  always_comb begin
    wordAfter = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (int'(lastIdx) == w) wordAfter = enVec[w*GATES_PER_WORD +: GATES_PER_WORD];
  end

  // R2
  masked_bits_written_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctlWrite |=> (((wordAfter ^ $past(wrData[15:0])) & $past(wrData[31:16])) == 16'h0));

  // R7
  no_stray_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ctlWrite |=> $stable(enVec));

  // R3
  ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctlRead |=> (rdData[31:16] == 16'h0));

  // R8
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.anyRead && !strb.ctlRead && !strb.monRead) |=> (rdData == 32'h0));
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank
  import cgb_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int SETTLE_CYCLES = 4,
  parameter logic [NUM_WORDS*16-1:0] CRIT_MASK = 32'h0001_8001,
  parameter logic [NUM_WORDS*16-1:0] MON_MASK = 32'h7FFF_7FFF
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                wrEn,
  input  logic                                rdEn,
  input  logic [11:0]                         addr,
  input  logic [31:0]                         wrData,
  output logic [31:0]                         rdData,
  output logic [NUM_WORDS*16-1:0]             gateEn,
  input  logic [$clog2(NUM_WORDS*16)-1:0]     statusIdx,
  output logic                                statusOn
);
  busStrobes_t strb;

  cgb_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  cgb_datapath #(
    .NUM_WORDS    (NUM_WORDS),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .CRIT_MASK    (CRIT_MASK),
    .MON_MASK     (MON_MASK)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .statusIdx(statusIdx),
    .enVec    (gateEn),
    .rdData   (rdData),
    .statusOn (statusOn)
  );
endmodule

// File: tb/tb_clk_gate_bank.sv
`timescale 1ns/1ps
module tb_clk_gate_bank;
  localparam int NW = 2;
  localparam int NG = NW * 16;
  localparam int SETTLE = 4;
  localparam logic [NG-1:0] CRIT = 32'h0001_8001;
  localparam logic [NG-1:0] MON  = 32'h7FFF_7FFF;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0, rdData;
  logic [NG-1:0] gateEn;
  logic [4:0] statusIdx = '0;
  logic statusOn;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [NG-1:0] expEn;

  always #2.5 clk = ~clk;

  clk_gate_bank #(.NUM_WORDS(NW), .SETTLE_CYCLES(SETTLE), .CRIT_MASK(CRIT), .MON_MASK(MON)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .gateEn(gateEn), .statusIdx(statusIdx), .statusOn(statusOn));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] modelWrite(input logic [15:0] cur, input logic [31:0] d);
    return (cur & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); d = rdData; rdEn = 1'b0;
  endtask

  task automatic ctlWrite(input int w, input logic [31:0] d);
    expEn[w*16 +: 16] = modelWrite(expEn[w*16 +: 16], d);
    busWrite(12'h600 + 12'(4*w), d);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd4242));
    expEn = CRIT;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 gateEn after reset", gateEn, CRIT);
    busRead(12'h800, rd); chk("R1 monitor word0 after reset", rd, {16'h0, CRIT[15:0] & MON[15:0]});
    busRead(12'h804, rd); chk("R1 monitor word1 after reset", rd, {16'h0, CRIT[31:16] & MON[31:16]});

    // R2 directed: turn gate 3 on without touching others
    ctlWrite(0, 32'h0008_FFFF);
    chk("R2 single bit on", gateEn, expEn);
    // R4 before settle / after settle on gate 3 (monitored), R6 status
    statusIdx = 5'd3;
    repeat (SETTLE - 1) @(negedge clk);
    chk("R4 monitor still off before settle", {31'h0, statusOn}, 32'h0);
    @(negedge clk);
    chk("R6 R4 monitor on at settle", {31'h0, statusOn}, 32'h1);
    // R4 falling direction
    ctlWrite(0, 32'h0008_0000);
    chk("R2 single bit off", gateEn, expEn);
    repeat (SETTLE - 1) @(negedge clk);
    chk("R4 monitor still on before settle (off)", {31'h0, statusOn}, 32'h1);
    @(negedge clk);
    chk("R4 monitor off at settle", {31'h0, statusOn}, 32'h0);

    // R5 unmonitored gate 31
    statusIdx = 5'd31;
    ctlWrite(1, 32'h8000_8000);
    chk("R5 status follows enable at once", {31'h0, statusOn}, 32'h1);
    repeat (SETTLE + 2) @(negedge clk);
    busRead(12'h804, rd);
    chk("R5 monitor bit 31 reads zero", rd, {16'h0, expEn[31:16] & MON[31:16]});
    // R3 control read upper zero
    busRead(12'h604, rd); chk("R3 control word1 read", rd, {16'h0, expEn[31:16]});

    // R7 writes to monitor word / unmapped / misaligned
    busWrite(12'h800, 32'hFFFF_FFFF); chk("R7 monitor write ignored", gateEn, expEn);
    busWrite(12'h608, 32'hFFFF_FFFF); chk("R7 unmapped write ignored", gateEn, expEn);
    busWrite(12'h602, 32'hFFFF_FFFF); chk("R7 misaligned write ignored", gateEn, expEn);
    busRead(12'h600, rd); chk("R7 control word0 unchanged", rd, {16'h0, expEn[15:0]});

    // R8 unmapped reads
    busRead(12'h700, rd); chk("R8 unmapped read", rd, 32'h0);
    busRead(12'h808, rd); chk("R8 past last monitor word", rd, 32'h0);
    busRead(12'h605, rd); chk("R8 misaligned read", rd, 32'h0);

    // random masked writes
    for (int i = 0; i < 60; i++) begin
      int w = int'($urandom_range(0, NW - 1));
      logic [31:0] d = $urandom;
      logic [4:0] g = 5'($urandom_range(0, NG - 1));
      ctlWrite(w, d);
      chk("R2 random masked write", gateEn, expEn);
      repeat (SETTLE + 1) @(negedge clk);
      statusIdx = g;
      #0.1;
      chk("R6 R5 random status", {31'h0, statusOn}, {31'h0, expEn[g]});
      busRead(12'h600 + 12'(4*w), rd);
      chk("R3 random control read", rd, {16'h0, expEn[w*16 +: 16]});
      busRead(12'h800 + 12'(4*w), rd);
      chk("R8 R4 random monitor read", rd, {16'h0, expEn[w*16 +: 16] & MON[w*16 +: 16]});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule